// File: doc/BRIEF.md
# High-Speed Burst Lane Serializer

This block sends one high-speed burst on a serial data lane and runs the matching clock lane. A burst request starts a low-power preamble on the two single-ended lines: lines high, then line P low, then both lines low. Each step lasts a number of cycles set by a configuration input. The lane then switches to high-speed signalling. It sends the fixed start-of-transmission sync byte first, and then the payload bytes in order. Two bits are emitted per cycle of the forward clock, the earlier bit in `hs_pair[0]`.

Payload bytes arrive on a valid/ready byte stream. A byte flagged as last closes the burst. The stream may not stall inside a burst: if no byte is offered when one is due, the block flags an underrun and closes the burst at once. Every burst ends with a trail state, which is the complement of the last bit sent, held for a programmed number of cycles. The lines then return high and a one-cycle done pulse shows that the next request will be taken. The clock lane is in high-speed mode for the whole high-speed part of the burst. Its first and last high-speed cycles are spent in the low differential state.

Top module: `hs_burst_tx`

## Requirements
- R1: After reset and whenever no burst is in progress, both lines are high (`lp_dp`=1, `lp_dn`=1), `lane_idle` is 1, `hs_en` is 0, `clk_hs_en` is 0 and `s_ready` is 0.
- R2: The cycle after `burst_req` is sampled high in idle, the lines show 11 for N11 cycles, then 01 (`lp_dp`=0, `lp_dn`=1) for N01 cycles, then 00 for N00 cycles. Each N is taken from its configuration input, and a configured 0 counts as 1.
- R3: High-speed output (`hs_en`=1) begins with the sync byte 0x1D, sent least significant bit first, two bits per cycle. Cycle k carries bits 2k (in `hs_pair[0]`) and 2k+1 (in `hs_pair[1]`). Both lines are 00 while `hs_en` is 1.
- R4: Payload bytes follow the sync byte without gaps, each taking four cycles in the bit order of R3. `s_ready` is 1 only in the fourth cycle of the sync byte and in the fourth cycle of each payload byte that is not flagged last. A byte is taken on a clock edge where `s_ready` and `s_valid` are both 1.
- R5: After the last bit sent, `hs_en` stays 1 for NT trail cycles (NT from `cfg_trail_cyc`, 0 counting as 1). In those cycles both bits of `hs_pair` equal the complement of the last bit sent.
- R6: After the trail, one cycle has the lines at 11 with `hs_en` 0. Then the lane is idle, and `burst_done` is 1 for exactly the first idle cycle.
- R7: `clk_hs_en` is 1 from the first cycle with the lines at 00 through the cycle after the trail. `clk_pair` is 00 in the preamble-00 cycles and in that final cycle, and 2'b10 (low then high) in every sync, payload and trail cycle.
- R8: If `s_valid` is 0 in a cycle where `s_ready` is 1, no byte is taken and the trail begins in the next cycle. `underrun` is 1 for exactly that first trail cycle. The trail value follows the last bit actually sent, which is the sync byte's bit 7 (0) if no payload byte was taken.
- R9: `burst_req` has no effect while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forward clock, one high-speed bit pair per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_req | input | 1 | Starts a burst when sampled high in idle |
| cfg_lp11_cyc | input | CNT_W | Cycles of the 11 preamble step |
| cfg_lp01_cyc | input | CNT_W | Cycles of the 01 preamble step |
| cfg_lp00_cyc | input | CNT_W | Cycles of the 00 preamble step |
| cfg_trail_cyc | input | CNT_W | Cycles of the trail state |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte is offered |
| s_last | input | 1 | Offered byte closes the burst |
| s_ready | output | 1 | Block takes the offered byte at this edge |
| lp_dp | output | 1 | Low-power level of line P |
| lp_dn | output | 1 | Low-power level of line N |
| hs_en | output | 1 | Data lane in high-speed mode |
| hs_pair | output | 2 | Differential data states for this cycle, [0] first |
| clk_hs_en | output | 1 | Clock lane in high-speed mode |
| clk_pair | output | 2 | Clock lane states for this cycle, [0] first |
| lane_idle | output | 1 | Lane idle, a request is accepted |
| burst_done | output | 1 | One-cycle pulse on return to idle |
| underrun | output | 1 | One-cycle pulse when the stream ran dry mid-burst |

## Verification
The byte slot and the burst end can fall in the same cycle. In the fourth cycle of a byte, one decision either takes the next byte or ends the burst, by the last flag or by a missing byte. The bench provokes an underrun at the sync-byte slot and another after several payload bytes. It also closes one burst with the last flag and a one-cycle trail, so the trail begins straight after a slot. The scoreboard then checks each cycle's lines, bit pair, clock pair, `s_ready` and pulses against a cycle list built from the configured counts and payload, so a taken byte, a missed trail or a misplaced `underrun` all show up as a mismatched cycle.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LP11  = 3'd1,
    ST_LP01  = 3'd2,
    ST_LP00  = 3'd3,
    ST_SYNC  = 3'd4,
    ST_DATA  = 3'd5,
    ST_TRAIL = 3'd6,
    ST_POST  = 3'd7
  } lane_st_e;

  localparam logic [7:0] SOT_SYNC = 8'h1D;
  localparam logic [1:0] CLK_TOGGLE = 2'b10;

  // two bits of a byte for a given quarter, lower bit first
  function automatic logic [1:0] pair_at(input logic [7:0] b, input logic [1:0] ph);
    return b[{ph, 1'b0} +: 2];
  endfunction

  function automatic logic is_hs(input lane_st_e s);
    return (s == ST_SYNC) || (s == ST_DATA) || (s == ST_TRAIL);
  endfunction

endpackage

// File: rtl/hs_lane_fsm.sv
module hs_lane_fsm
  import hs_lane_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_req,
  input  logic [CNT_W-1:0] cfg_lp11_cyc,
  input  logic [CNT_W-1:0] cfg_lp01_cyc,
  input  logic [CNT_W-1:0] cfg_lp00_cyc,
  input  logic [CNT_W-1:0] cfg_trail_cyc,
  input  logic             s_valid,
  input  logic             s_last,
  output lane_st_e         st,
  output logic [1:0]       phase,
  output logic             slot,
  output logic             take,
  output logic             dry,
  output logic             load_sync,
  output logic             err_q,
  output logic             done_q
);

  logic [CNT_W-1:0] tmr;
  logic             last_q;

  // count reload: a programmed zero behaves as one cycle
  function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  assign slot      = (phase == 2'd3) && ((st == ST_SYNC) || ((st == ST_DATA) && !last_q));
  assign take      = slot && s_valid;
  assign dry       = slot && !s_valid;
  assign load_sync = (st == ST_LP00) && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      phase  <= 2'd0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= dry;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (burst_req) begin
            st     <= ST_LP11;
            tmr    <= span_m1(cfg_lp11_cyc);
            last_q <= 1'b0;
          end
        end
        ST_LP11: begin
          if (tmr == '0) begin
            st  <= ST_LP01;
            tmr <= span_m1(cfg_lp01_cyc);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_LP01: begin
          if (tmr == '0) begin
            st  <= ST_LP00;
            tmr <= span_m1(cfg_lp00_cyc);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_LP00: begin
          if (tmr == '0) begin
            st    <= ST_SYNC;
            phase <= 2'd0;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_SYNC, ST_DATA: begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (take) begin
              st     <= ST_DATA;
              last_q <= s_last;
            end else begin
              st  <= ST_TRAIL;
              tmr <= span_m1(cfg_trail_cyc);
            end
          end
        end
        ST_TRAIL: begin
          if (tmr == '0) st <= ST_POST;
          else           tmr <= tmr - 1'b1;
        end
        ST_POST: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_byte_shifter.sv
module hs_byte_shifter
  import hs_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_sync,
  input  logic       take,
  input  logic [7:0] s_data,
  input  logic [1:0] phase,
  output logic [1:0] pair,
  output logic       trail_bit
);

  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh <= '0;
    else if (load_sync) sh <= SOT_SYNC;
    else if (take)      sh <= s_data;
  end

  assign pair      = pair_at(sh, phase);
  // the register still holds the byte just finished when the trail starts
  assign trail_bit = ~sh[7];

endmodule

// File: rtl/hs_clk_lane.sv
module hs_clk_lane
  import hs_lane_pkg::*;
(
  input  lane_st_e   st,
  output logic       clk_hs_en,
  output logic [1:0] clk_pair
);

  always_comb begin
    clk_hs_en = 1'b0;
    clk_pair  = 2'b00;
    case (st)
      ST_LP00, ST_POST: clk_hs_en = 1'b1;
      ST_SYNC, ST_DATA, ST_TRAIL: begin
        clk_hs_en = 1'b1;
        clk_pair  = CLK_TOGGLE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hs_burst_tx.sv
module hs_burst_tx
  import hs_lane_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_req,
  input  logic [CNT_W-1:0] cfg_lp11_cyc,
  input  logic [CNT_W-1:0] cfg_lp01_cyc,
  input  logic [CNT_W-1:0] cfg_lp00_cyc,
  input  logic [CNT_W-1:0] cfg_trail_cyc,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic             lp_dp,
  output logic             lp_dn,
  output logic             hs_en,
  output logic [1:0]       hs_pair,
  output logic             clk_hs_en,
  output logic [1:0]       clk_pair,
  output logic             lane_idle,
  output logic             burst_done,
  output logic             underrun
);

  lane_st_e   st;
  logic [1:0] phase;
  logic       slot_ev;
  logic       take_ev;
  logic       dry_ev;
  logic       load_sync;
  logic [1:0] byte_pair;
  logic       trail_bit;

  hs_lane_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .burst_req     (burst_req),
    .cfg_lp11_cyc  (cfg_lp11_cyc),
    .cfg_lp01_cyc  (cfg_lp01_cyc),
    .cfg_lp00_cyc  (cfg_lp00_cyc),
    .cfg_trail_cyc (cfg_trail_cyc),
    .s_valid       (s_valid),
    .s_last        (s_last),
    .st            (st),
    .phase         (phase),
    .slot          (slot_ev),
    .take          (take_ev),
    .dry           (dry_ev),
    .load_sync     (load_sync),
    .err_q         (underrun),
    .done_q        (burst_done)
  );

  hs_byte_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_sync (load_sync),
    .take      (take_ev),
    .s_data    (s_data),
    .phase     (phase),
    .pair      (byte_pair),
    .trail_bit (trail_bit)
  );

  hs_clk_lane u_clk (
    .st        (st),
    .clk_hs_en (clk_hs_en),
    .clk_pair  (clk_pair)
  );

  assign s_ready   = slot_ev;
  assign lane_idle = (st == ST_IDLE);
  assign hs_en     = is_hs(st);

  always_comb begin
    hs_pair = 2'b00;
    if (st == ST_TRAIL)                        hs_pair = {2{trail_bit}};
    else if ((st == ST_SYNC) || (st == ST_DATA)) hs_pair = byte_pair;
  end

  always_comb begin
    case (st)
      ST_LP01:                    {lp_dp, lp_dn} = 2'b01;
      ST_LP00, ST_SYNC, ST_DATA,
      ST_TRAIL:                   {lp_dp, lp_dn} = 2'b00;
      default:                    {lp_dp, lp_dn} = 2'b11;
    endcase
  end

endmodule

// File: rtl/hs_burst_tx_chk.sv
module hs_burst_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_dp,
  input logic       lp_dn,
  input logic       hs_en,
  input logic [1:0] hs_pair,
  input logic       clk_hs_en,
  input logic [1:0] clk_pair,
  input logic       s_ready,
  input logic       lane_idle,
  input logic       burst_done,
  input logic       underrun,
  input logic       dry_ev
);

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    lane_idle |-> (lp_dp && lp_dn && !hs_en && !clk_hs_en && !s_ready)); // R1

  AST_HS_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!lp_dp && !lp_dn)); // R3

  AST_READY_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (hs_en && clk_hs_en)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done); // R6

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (lane_idle && !clk_hs_en)); // R6

  AST_CLK_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_hs_en) |-> (clk_pair == 2'b00)); // R7

  AST_CLK_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_hs_en) |-> ($past(clk_pair) == 2'b00)); // R7

  AST_DRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dry_ev |=> (underrun && hs_en && (hs_pair[0] == hs_pair[1]))); // R8

  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R8

endmodule

bind hs_burst_tx hs_burst_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lp_dp      (lp_dp),
  .lp_dn      (lp_dn),
  .hs_en      (hs_en),
  .hs_pair    (hs_pair),
  .clk_hs_en  (clk_hs_en),
  .clk_pair   (clk_pair),
  .s_ready    (s_ready),
  .lane_idle  (lane_idle),
  .burst_done (burst_done),
  .underrun   (underrun),
  .dry_ev     (dry_ev)
);

// File: tb/hs_burst_tx_test.sv
`timescale 1ns/1ps
module hs_burst_tx_test;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          burst_req = 1'b0;
  logic [CW-1:0] c11 = '0, c01 = '0, c00 = '0, ctr = '0;
  logic [7:0]    s_data = '0;
  logic          s_valid = 1'b0, s_last = 1'b0;
  logic          s_ready, lp_dp, lp_dn, hs_en, clk_hs_en, lane_idle, burst_done, underrun;
  logic [1:0]    hs_pair, clk_pair;

  int chk_cnt = 0;
  int fail_cnt = 0;

  always #2.5 clk = ~clk;

  hs_burst_tx #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req),
    .cfg_lp11_cyc(c11), .cfg_lp01_cyc(c01), .cfg_lp00_cyc(c00), .cfg_trail_cyc(ctr),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .lp_dp(lp_dp), .lp_dn(lp_dn), .hs_en(hs_en), .hs_pair(hs_pair),
    .clk_hs_en(clk_hs_en), .clk_pair(clk_pair),
    .lane_idle(lane_idle), .burst_done(burst_done), .underrun(underrun)
  );

  // {dp,dn,hs_en,hs_pair,clk_en,clk_pair,s_ready,underrun,done,idle}
  typedef struct {
    logic [11:0] v;
    string       tag;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] pay[$];

  function automatic exp_t mk(bit dp, bit dn, bit he, bit [1:0] hp, bit ce, bit [1:0] cp,
                              bit sr, bit er, bit dn_o, bit idl, string tag);
    exp_t e;
    e.v   = {dp, dn, he, hp, ce, cp, sr, er, dn_o, idl};
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [11:0] act_vec();
    return {lp_dp, lp_dn, hs_en, hs_pair, clk_hs_en, clk_pair, s_ready, underrun, burst_done, lane_idle};
  endfunction

  task automatic check(input logic [11:0] a, input logic [11:0] e, input string tag);
    chk_cnt++;
    if (a !== e) begin
      fail_cnt++;
      $display("FAIL %s at %0t: act=%b exp=%b", tag, $time, a, e);
    end
  endtask

  // scoreboard monitor; clock-lane fields (R7) are part of every item
  initial begin
    forever begin
      @(negedge clk);
      if (expq.size() != 0) begin
        exp_t e;
        e = expq.pop_front();
        check(act_vec(), e.v, e.tag);
      end
    end
  end

  function automatic int span(input logic [CW-1:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  task automatic feed(input bit dry);
    int n;
    n = pay.size();
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_data  = pay[i];
      s_last  = !dry && (i == n - 1);
      do @(negedge clk); while (!s_ready);
      @(posedge clk);
      #1;
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic push_expected(input bit dry, input bit poke);
    string pre;
    int    n;
    bit    lb;
    logic [7:0] sb;
    n   = pay.size();
    pre = poke ? "R9+" : "";
    for (int i = 0; i < span(c11); i++) expq.push_back(mk(1,1,0,2'b00,0,2'b00,0,0,0,0,{pre,"R2"}));
    for (int i = 0; i < span(c01); i++) expq.push_back(mk(0,1,0,2'b00,0,2'b00,0,0,0,0,{pre,"R2"}));
    for (int i = 0; i < span(c00); i++) expq.push_back(mk(0,0,0,2'b00,1,2'b00,0,0,0,0,{pre,"R2"}));
    sb = 8'h1D;
    for (int k = 0; k < 4; k++)
      expq.push_back(mk(0,0,1,{sb[2*k+1],sb[2*k]},1,2'b10,(k==3),0,0,0,{pre,"R3"}));
    for (int j = 0; j < n; j++) begin
      logic [7:0] b;
      b = pay[j];
      for (int k = 0; k < 4; k++)
        expq.push_back(mk(0,0,1,{b[2*k+1],b[2*k]},1,2'b10,(k==3)&&(dry||j<n-1),0,0,0,{pre,"R4"}));
    end
    lb = (n > 0) ? pay[n-1][7] : 1'b0;
    for (int t = 0; t < span(ctr); t++)
      expq.push_back(mk(0,0,1,{~lb,~lb},1,2'b10,0,dry&&(t==0),0,0,{pre, dry ? "R8" : "R5"}));
    expq.push_back(mk(1,1,0,2'b00,1,2'b00,0,0,0,0,{pre,"R6"}));
    expq.push_back(mk(1,1,0,2'b00,0,2'b00,0,0,1,1,{pre,"R6"}));
    expq.push_back(mk(1,1,0,2'b00,0,2'b00,0,0,0,1,{pre,"R1"}));
  endtask

  task automatic run_burst(input bit dry, input bit poke);
    @(negedge clk);
    burst_req = 1'b1;
    @(posedge clk);
    #1;
    burst_req = 1'b0;
    push_expected(dry, poke);
    fork
      feed(dry);
    join_none
    if (poke) begin
      // R9: a request while busy must leave the sequence untouched
      repeat (3) @(negedge clk);
      burst_req = 1'b1;
      @(negedge clk);
      burst_req = 1'b0;
    end
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fail_cnt++;
    $display("FAIL watchdog: run did not finish, act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(act_vec(), {2'b11,1'b0,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0,1'b1}, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(act_vec(), {2'b11,1'b0,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0,1'b1}, "R1");

    // two bytes, last flag on the second
    c11 = 8'd2; c01 = 8'd1; c00 = 8'd3; ctr = 8'd2;
    pay = '{8'hA5, 8'h3C};
    run_burst(1'b0, 1'b0);

    // zero counts behave as one; one byte with bit 7 set; request while busy
    c11 = 8'd0; c01 = 8'd0; c00 = 8'd0; ctr = 8'd0;
    pay = '{8'h80};
    run_burst(1'b0, 1'b1);

    // underrun after three bytes
    c11 = 8'd1; c01 = 8'd2; c00 = 8'd1; ctr = 8'd3;
    pay = '{8'hFF, 8'h01, 8'h7E};
    run_burst(1'b1, 1'b0);

    // underrun at the sync-byte slot
    c11 = 8'd1; c01 = 8'd1; c00 = 8'd1; ctr = 8'd1;
    pay = '{};
    run_burst(1'b1, 1'b0);

    // longer burst, single-cycle trail straight after the last slot
    c11 = 8'd3; c01 = 8'd3; c00 = 8'd2; ctr = 8'd1;
    pay = '{8'h00, 8'hFF, 8'h5A, 8'hC3, 8'h81};
    run_burst(1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

endmodule